// File: doc/BRIEF.md
# Completion-Gated Store Queue

This block sits between a load/store pipeline and a data cache. Memory requests arrive one at a time, in program order, on a request port with a valid/ready handshake. A store is never written to the cache speculatively. It is parked in a small queue until the completion logic pulses a retire strobe, which marks the oldest unretired store as safe. Retired stores then drain to the cache in arrival order, one per cycle.

Loads do not wait behind the parked stores. A load whose word address matches no queued store goes straight to the cache and may read memory ahead of older stores. A load whose address matches a queued store is held at the request port until that store has been written. A sync request is held at the port until every earlier store has been written, so nothing that follows it can overtake them. A speculation-flush input discards every store that has not been retired yet and keeps the retired ones.

The cache port is a single shared port with registered request outputs and read data returned one cycle after a read request. Load data comes back in request order on a separate return port.

Top module: `store_commit_queue`

## Requirements
- R1: After reset, the cache enable and the load-return valid are low, and the queue is empty, so both a store request and a sync request see ready high.
- R2: A load accepted at a clock edge raises the load-return valid for one cycle after the second following edge, carrying the cache word at its address. Back-to-back loads return in order on consecutive cycles.
- R3: A queued store that has not been retired never produces a cache write.
- R4: A store accepted at an edge and retired by a strobe held in the next cycle shows its write on the cache port after the second following edge, and the memory holds the new word after the third.
- R5: Each retire strobe marks the oldest unretired store. Retired stores are written to the cache in their arrival order.
- R6: A load whose word address matches no queued store is accepted while older unretired stores are queued, and it returns the memory contents from before those stores.
- R7: A load whose word address matches any queued store sees ready low until that store has been written, and it then returns the stored word.
- R8: In any cycle in which a retired store waits at the head of the queue, the store takes the cache port and a load request sees ready low.
- R9: The queue holds DEPTH stores (default 4). With DEPTH stores queued, a store request sees ready low. Stores are otherwise accepted one per cycle.
- R10: A sync request sees ready high only when the queue is empty. The operation code is 2'b00 for a load, 2'b01 for a store, and any value with bit 1 set for a sync.
- R11: A flush removes every unretired store and keeps the retired ones. A retire strobe in the same cycle as a flush is applied first. Discarded stores are never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_op | input | 2 | 00 load, 01 store, 1x sync |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store data |
| retire_st | input | 1 | Completion strobe: retire the oldest unretired store |
| flush_spec | input | 1 | Discard every unretired store |
| cache_en | output | 1 | Cache access request (registered) |
| cache_we | output | 1 | Request is a write |
| cache_addr | output | AW | Cache word address |
| cache_wdata | output | DW | Cache write data |
| cache_rdata | input | DW | Read data, valid the cycle after a read request |
| ld_valid | output | 1 | Load data valid |
| ld_data | output | DW | Load data |

## Verification
Two functions can collide in the same cycle. A retired store can reach the head of the queue while a new load asks for the single cache port. The bench pulses the retire strobe and then presents an unrelated load in the next cycle. It expects ready low for that one cycle, the store's write two edges after its acceptance, and the load accepted one cycle later with its own data. A retire strobe and a flush are also raised in the same cycle. The bench judges that pair by which addresses are later written and by what loads then read from the discarded addresses.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam logic [1:0] OPC_LOAD  = 2'b00;
  localparam logic [1:0] OPC_STORE = 2'b01;
endpackage

// File: rtl/sq_store_fifo.sv
module sq_store_fifo #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [AW-1:0]                push_addr,
  input  logic [DW-1:0]                push_data,
  input  logic                         pop,
  input  logic                         retire,
  input  logic                         flush,
  input  logic [AW-1:0]                probe_addr,
  output logic [$clog2(DEPTH):0]       count,
  output logic [$clog2(DEPTH):0]       rcount,
  output logic [AW-1:0]                head_addr,
  output logic [DW-1:0]                head_data,
  output logic                         full,
  output logic                         empty,
  output logic                         has_retired,
  output logic                         hit
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [PW-1:0]  head;
  logic [PW-1:0]  wr_idx;
  logic           retire_ok;
  logic [CW-1:0]  count_step, rcount_step;
  logic [AW-1:0]  addr_q [DEPTH];
  logic [DW-1:0]  data_q [DEPTH];
  logic [DEPTH-1:0] match;

  // Slot after the youngest entry; wraps because DEPTH is a power of two.
  assign wr_idx    = head + count[PW-1:0];
  // Only an entry that is still unretired can be retired.
  assign retire_ok = retire && (rcount < count);

  always_comb begin
    count_step  = count + CW'(push) - CW'(pop);
    rcount_step = rcount + CW'(retire_ok) - CW'(pop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head   <= '0;
      count  <= '0;
      rcount <= '0;
    end else begin
      head   <= head + PW'(pop);
      // A flush rewinds the fill level to the retired part of the queue.
      count  <= flush ? rcount_step : count_step;
      rcount <= rcount_step;
    end
  end

  // Storage without reset, single write port.
  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_idx] <= push_addr;
      data_q[wr_idx] <= push_data;
    end
  end

  assign head_addr   = addr_q[head];
  assign head_data   = data_q[head];
  assign full        = (count == CW'(DEPTH));
  assign empty       = (count == '0);
  assign has_retired = (rcount != '0);

  // Parallel word-address compare against every live slot.
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cmp
    logic [PW-1:0] age;
    assign age       = PW'(gi) - head;
    assign match[gi] = ({1'b0, age} < count) && (addr_q[gi] == probe_addr);
  end
  assign hit = |match;
endmodule

// File: rtl/sq_port_arb.sv
module sq_port_arb
  import sq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic          flush,
  input  logic          has_retired,
  input  logic          hit,
  input  logic          full,
  input  logic          empty,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  output logic          req_ready,
  output logic          push,
  output logic          pop,
  output logic          cache_en,
  output logic          cache_we,
  output logic [AW-1:0] cache_addr,
  output logic [DW-1:0] cache_wdata
);
  logic ld_ok, st_ok, sy_ok, accept, ld_acc;

  // A retired store owns the port, and a load may not pass a matching store.
  assign ld_ok = !flush && !has_retired && !hit;
  assign st_ok = !flush && !full;
  assign sy_ok = !flush && empty;

  always_comb begin
    if (req_op[1])                req_ready = sy_ok;
    else if (req_op == OPC_STORE) req_ready = st_ok;
    else                          req_ready = ld_ok;
  end

  assign accept = req_valid && req_ready;
  assign push   = accept && (req_op == OPC_STORE);
  assign ld_acc = accept && (req_op == OPC_LOAD);
  assign pop    = has_retired;

  always_ff @(posedge clk) begin
    if (rst) begin
      cache_en    <= 1'b0;
      cache_we    <= 1'b0;
      cache_addr  <= '0;
      cache_wdata <= '0;
    end else begin
      cache_en <= pop || ld_acc;
      cache_we <= pop;
      if (pop) begin
        cache_addr  <= head_addr;
        cache_wdata <= head_data;
      end else if (ld_acc) begin
        cache_addr  <= req_addr;
      end
    end
  end
endmodule

// File: rtl/sq_load_ret.sv
module sq_load_ret #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cache_en,
  input  logic          cache_we,
  input  logic [DW-1:0] cache_rdata,
  output logic          ld_valid,
  output logic [DW-1:0] ld_data
);
  logic rd_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend  <= 1'b0;
      ld_valid <= 1'b0;
      ld_data  <= '0;
    end else begin
      rd_pend  <= cache_en && !cache_we;
      ld_valid <= rd_pend;
      if (rd_pend) ld_data <= cache_rdata;
    end
  end
endmodule

// File: rtl/store_commit_queue.sv
module store_commit_queue #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          retire_st,
  input  logic          flush_spec,
  output logic          cache_en,
  output logic          cache_we,
  output logic [AW-1:0] cache_addr,
  output logic [DW-1:0] cache_wdata,
  input  logic [DW-1:0] cache_rdata,
  output logic          ld_valid,
  output logic [DW-1:0] ld_data
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic          q_push, q_pop, q_full, q_empty, q_has_retired, q_hit;
  logic [CW-1:0] q_count, q_rcount;
  logic [AW-1:0] q_head_addr;
  logic [DW-1:0] q_head_data;

  sq_store_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
    .clk(clk), .rst(rst),
    .push(q_push), .push_addr(req_addr), .push_data(req_wdata),
    .pop(q_pop), .retire(retire_st), .flush(flush_spec),
    .probe_addr(req_addr),
    .count(q_count), .rcount(q_rcount),
    .head_addr(q_head_addr), .head_data(q_head_data),
    .full(q_full), .empty(q_empty), .has_retired(q_has_retired), .hit(q_hit)
  );

  sq_port_arb #(.AW(AW), .DW(DW)) u_arb (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .flush(flush_spec), .has_retired(q_has_retired), .hit(q_hit),
    .full(q_full), .empty(q_empty),
    .head_addr(q_head_addr), .head_data(q_head_data),
    .req_ready(req_ready), .push(q_push), .pop(q_pop),
    .cache_en(cache_en), .cache_we(cache_we),
    .cache_addr(cache_addr), .cache_wdata(cache_wdata)
  );

  sq_load_ret #(.DW(DW)) u_ret (
    .clk(clk), .rst(rst),
    .cache_en(cache_en), .cache_we(cache_we), .cache_rdata(cache_rdata),
    .ld_valid(ld_valid), .ld_data(ld_data)
  );
endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_op,
  input logic          flush_spec,
  input logic          cache_en,
  input logic          cache_we,
  input logic          ld_valid,
  input logic [CW-1:0] q_count,
  input logic [CW-1:0] q_rcount,
  input logic          q_hit,
  input logic          q_has_retired
);
  // R3
  write_needs_retire_chk: assert property (@(posedge clk) disable iff (rst)
    (cache_en && cache_we) |-> ($past(q_rcount) != '0));

  // R2
  load_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_op == 2'b00) |=> (cache_en && !cache_we));

  // R2
  load_return_chk: assert property (@(posedge clk) disable iff (rst)
    (cache_en && !cache_we) |=> ##1 ld_valid);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (q_count <= CW'(DEPTH)) && !(q_count == CW'(DEPTH) && req_op == 2'b01 && req_ready));

  // R8
  drain_first_chk: assert property (@(posedge clk) disable iff (rst)
    (q_has_retired && req_op == 2'b00) |-> !req_ready);

  // R7
  conflict_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (q_hit && req_op == 2'b00) |-> !req_ready);

  // R10
  sync_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_op[1]) |-> (q_count == '0));

  // R11
  flush_keep_chk: assert property (@(posedge clk) disable iff (rst)
    flush_spec |=> (q_count == q_rcount));
endmodule

bind store_commit_queue sq_checker #(.DEPTH(DEPTH)) u_sq_checker (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .flush_spec(flush_spec), .cache_en(cache_en),
  .cache_we(cache_we), .ld_valid(ld_valid), .q_count(q_count),
  .q_rcount(q_rcount), .q_hit(q_hit), .q_has_retired(q_has_retired)
);

// File: tb/test_store_commit_queue.sv
`timescale 1ns/1ps
module test_store_commit_queue;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic retire_st = 1'b0;
  logic flush_spec = 1'b0;
  logic [DW-1:0] cache_rdata = '0;
  logic req_ready, cache_en, cache_we, ld_valid;
  logic [AW-1:0] cache_addr;
  logic [DW-1:0] cache_wdata, ld_data;

  store_commit_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_store_commit_queue (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .retire_st(retire_st), .flush_spec(flush_spec),
    .cache_en(cache_en), .cache_we(cache_we), .cache_addr(cache_addr),
    .cache_wdata(cache_wdata), .cache_rdata(cache_rdata),
    .ld_valid(ld_valid), .ld_data(ld_data)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 0;

  logic [DW-1:0] mem [1<<AW];
  int wl_n = 0;
  int wl_addr [64];
  logic [DW-1:0] wl_data [64];
  int wl_cyc [64];
  int rl_n = 0;
  logic [DW-1:0] rl_data [64];
  int rl_cyc [64];

  function automatic logic [DW-1:0] init_word(int a);
    return 32'hA000_0000 | DW'(a);
  endfunction

  initial for (int i = 0; i < (1 << AW); i++) mem[i] = init_word(i);

  // Cache model: one shared port, read data one cycle after the request.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cache_en) begin
      if (cache_we) mem[cache_addr] <= cache_wdata;
      else          cache_rdata <= mem[cache_addr];
    end
  end

  always @(negedge clk) begin
    if (!rst && cache_en && cache_we && wl_n < 64) begin
      wl_addr[wl_n] = int'(cache_addr);
      wl_data[wl_n] = cache_wdata;
      wl_cyc[wl_n]  = cyc;
      wl_n++;
    end
    if (!rst && ld_valid && rl_n < 64) begin
      rl_data[rl_n] = ld_data;
      rl_cyc[rl_n]  = cyc;
      rl_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Presents one request and returns the cycle number seen after the accepting edge.
  task automatic issue(input logic [1:0] op, input int addr, input logic [DW-1:0] d,
                       output int acc, output int waits);
    waits = 0;
    req_valid = 1'b1; req_op = op; req_addr = AW'(addr); req_wdata = d;
    #1;
    while (!req_ready && waits < 60) begin
      @(negedge clk); #1; waits++;
    end
    if (waits >= 60) chk(0, "R2", "request never accepted", 64'(waits), 64'd0);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    acc = cyc;
  endtask

  task automatic pulse_retire();
    retire_st = 1'b1;
    @(negedge clk);
    retire_st = 1'b0;
  endtask

  task automatic load_check(input int addr, input logic [DW-1:0] exp, input string req);
    int acc, w;
    issue(2'b00, addr, '0, acc, w);
    chk(ld_valid == 1'b0, req, "load valid one cycle early", 64'(ld_valid), 64'd0);
    @(negedge clk);
    chk(ld_valid == 1'b0, req, "load valid early", 64'(ld_valid), 64'd0);
    @(negedge clk);
    chk(ld_valid == 1'b1, req, "load valid two edges after accept", 64'(ld_valid), 64'd1);
    chk(ld_data == exp, req, "load data", 64'(ld_data), 64'(exp));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(cache_en == 1'b0, "R1", "cache enable after reset", 64'(cache_en), 64'd0);
    chk(ld_valid == 1'b0, "R1", "load valid after reset", 64'(ld_valid), 64'd0);
    req_op = 2'b01; #0.1;
    chk(req_ready == 1'b1, "R1", "store ready after reset", 64'(req_ready), 64'd1);
    req_op = 2'b10; #0.1;
    chk(req_ready == 1'b1, "R10", "sync ready on empty queue", 64'(req_ready), 64'd1);
    req_op = 2'b00;
    @(negedge clk);
  endtask

  task automatic t_load_basic();
    load_check(5, init_word(5), "R2");
  endtask

  task automatic t_store_retire();
    int acc, w, wn;
    issue(2'b01, 10, 32'h1111_0010, acc, w);
    wn = wl_n;
    repeat (5) @(negedge clk);
    #1;
    chk(wl_n == wn, "R3", "write before retire", 64'(wl_n), 64'(wn));
    pulse_retire();
    repeat (3) @(negedge clk);
    #1;
    chk(wl_n == wn + 1, "R3", "write count after retire", 64'(wl_n), 64'(wn + 1));
    chk(wl_addr[wn] == 10 && wl_data[wn] == 32'h1111_0010, "R3", "retired write addr",
        64'(wl_addr[wn]), 64'd10);
    @(negedge clk);
    issue(2'b01, 11, 32'h2222_0011, acc, w);
    wn = wl_n;
    pulse_retire();
    @(negedge clk);
    #1;
    chk(wl_n == wn + 1 && wl_cyc[wn] == acc + 2, "R4", "write cycle after accept",
        64'(wl_cyc[wn]), 64'(acc + 2));
    @(negedge clk);
    load_check(11, 32'h2222_0011, "R4");
  endtask

  task automatic t_bypass();
    int acc, w;
    issue(2'b01, 20, 32'h3333_0020, acc, w);
    issue(2'b00, 21, '0, acc, w);
    chk(w == 0, "R6", "bypass load waited", 64'(w), 64'd0);
    @(negedge clk); @(negedge clk);
    chk(ld_valid && ld_data == init_word(21), "R6", "bypass load data", 64'(ld_data), 64'(init_word(21)));
    req_valid = 1'b1; req_op = 2'b00; req_addr = AW'(20);
    #1;
    chk(req_ready == 1'b0, "R7", "matching load ready", 64'(req_ready), 64'd0);
    @(negedge clk); #1;
    chk(req_ready == 1'b0, "R7", "matching load ready later", 64'(req_ready), 64'd0);
    req_valid = 1'b0;
    pulse_retire();
    load_check(20, 32'h3333_0020, "R7");
  endtask

  task automatic t_fill_drain();
    int acc [4];
    int w, wn;
    for (int i = 0; i < 4; i++) issue(2'b01, 60 + i, 32'h4444_0000 + DW'(i), acc[i], w);
    for (int i = 1; i < 4; i++)
      chk(acc[i] == acc[0] + i, "R9", "stores one per cycle", 64'(acc[i]), 64'(acc[0] + i));
    req_valid = 1'b1; req_op = 2'b01; req_addr = AW'(64);
    #1;
    chk(req_ready == 1'b0, "R9", "store ready when full", 64'(req_ready), 64'd0);
    req_valid = 1'b0;
    wn = wl_n;
    retire_st = 1'b1;
    repeat (4) @(negedge clk);
    retire_st = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(wl_n == wn + 4, "R5", "drained writes", 64'(wl_n), 64'(wn + 4));
    for (int i = 0; i < 4; i++) begin
      chk(wl_addr[wn + i] == 60 + i, "R5", "drain order", 64'(wl_addr[wn + i]), 64'(60 + i));
      chk(wl_cyc[wn + i] == wl_cyc[wn] + i, "R5", "drain one per cycle",
          64'(wl_cyc[wn + i]), 64'(wl_cyc[wn] + i));
    end
    @(negedge clk);
  endtask

  task automatic t_priority();
    int acc, acc2, w, wn;
    issue(2'b01, 40, 32'h5555_0040, acc, w);
    wn = wl_n;
    pulse_retire();
    req_valid = 1'b1; req_op = 2'b00; req_addr = AW'(41);
    #1;
    chk(req_ready == 1'b0, "R8", "load ready while retired store waits", 64'(req_ready), 64'd0);
    issue(2'b00, 41, '0, acc2, w);
    chk(w == 1, "R8", "load waited one cycle", 64'(w), 64'd1);
    chk(wl_n >= wn + 1 && wl_addr[wn] == 40 && wl_cyc[wn] == acc + 2, "R8", "store write cycle",
        64'(wl_cyc[wn]), 64'(acc + 2));
    @(negedge clk); @(negedge clk);
    chk(ld_valid && ld_data == init_word(41), "R8", "load data after drain", 64'(ld_data), 64'(init_word(41)));
  endtask

  task automatic t_sync();
    int acc, w;
    issue(2'b01, 80, 32'h6666_0080, acc, w);
    req_valid = 1'b1; req_op = 2'b10;
    #1;
    chk(req_ready == 1'b0, "R10", "sync ready with store queued", 64'(req_ready), 64'd0);
    @(negedge clk); #1;
    chk(req_ready == 1'b0, "R10", "sync still held", 64'(req_ready), 64'd0);
    pulse_retire();
    issue(2'b11, 0, '0, acc, w);
    chk(wl_n > 0 && wl_addr[wl_n - 1] == 80 && wl_cyc[wl_n - 1] < acc, "R10",
        "sync accepted after write", 64'(acc), 64'(wl_cyc[wl_n - 1] + 1));
  endtask

  task automatic t_flush();
    int acc, w, wn;
    for (int i = 0; i < 3; i++) issue(2'b01, 90 + i, 32'h7777_0000 + DW'(i), acc, w);
    wn = wl_n;
    retire_st = 1'b1; flush_spec = 1'b1;
    @(negedge clk);
    retire_st = 1'b0; flush_spec = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(wl_n == wn + 1, "R11", "writes after flush", 64'(wl_n), 64'(wn + 1));
    chk(wl_addr[wn] == 90, "R11", "retired store kept", 64'(wl_addr[wn]), 64'd90);
    req_op = 2'b10; #0.1;
    chk(req_ready == 1'b1, "R11", "queue empty after flush", 64'(req_ready), 64'd1);
    @(negedge clk);
    load_check(91, init_word(91), "R11");
    @(negedge clk);
    load_check(92, init_word(92), "R11");
    @(negedge clk);
    issue(2'b01, 93, 32'h7777_0093, acc, w);
    wn = wl_n;
    pulse_retire();
    repeat (2) @(negedge clk);
    #1;
    chk(wl_n == wn + 1 && wl_addr[wn] == 93, "R11", "next retire hits new store",
        64'(wl_addr[wn]), 64'd93);
    @(negedge clk);
  endtask

  task automatic t_load_stream();
    int acc [3];
    int w, rn;
    rn = rl_n;
    for (int i = 0; i < 3; i++) issue(2'b00, 100 + i, '0, acc[i], w);
    for (int i = 1; i < 3; i++)
      chk(acc[i] == acc[0] + i, "R2", "loads one per cycle", 64'(acc[i]), 64'(acc[0] + i));
    repeat (3) @(negedge clk);
    #1;
    chk(rl_n == rn + 3, "R2", "load returns", 64'(rl_n), 64'(rn + 3));
    for (int i = 0; i < 3; i++) begin
      chk(rl_data[rn + i] == init_word(100 + i), "R2", "streamed data",
          64'(rl_data[rn + i]), 64'(init_word(100 + i)));
      chk(rl_cyc[rn + i] == acc[i] + 2, "R2", "streamed latency",
          64'(rl_cyc[rn + i]), 64'(acc[i] + 2));
    end
  endtask

  initial begin
    t_reset();
    t_load_basic();
    t_store_retire();
    t_bypass();
    t_fill_drain();
    t_priority();
    t_sync();
    t_flush();
    t_load_stream();
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule